// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a byte-wide SPI master placed behind a small register file that a processor reaches through a 2-bit address with single-cycle read and write strobes. Software programs the serial clock polarity, phase and rate in a control register and writes a byte to the data register. The block then shifts the byte out on `mosi`, most significant bit first, while it collects the byte arriving on `miso`. When the eighth bit completes, a completion flag is raised. An interrupt request follows that flag when it is enabled.

A data write made while a transfer is running is discarded and recorded as a collision. Flags never clear on their own. A status read first records which flags were set. The next access to the data register, read or write, then clears exactly those flags. Reads of the data register return the last received byte.

Top module: `spi_reg_master`

## Requirements
- R1: After a synchronous reset the control, status and data registers all read 0x00, `sck` is low and `irq` is low.
- R2: Address 0 is the control register. It reads back all 8 written bits. Bit 7 is the interrupt enable and bit 6 is the enable. Bits 5 and 4 are stored but have no function. Bit 3 sets the clock polarity, bit 2 sets the clock phase, and bits 1:0 are the rate code.
- R3: Address 1 is the status register. Bit 7 is the completion flag, bit 6 is the collision flag, and all other bits read 0. Writes to address 1 have no effect.
- R4: A write to address 2 while the enable bit is 0 starts no transfer, sets no flag, leaves `sck` idle and clears no flag.
- R5: A write to address 2 while the enable bit is 1 and a transfer is running sets the collision flag. The written byte is discarded and the running transfer continues unchanged.
- R6: An accepted write starts a transfer of 16 half-periods, each lasting H clocks, where H is 1, 2, 8 or 16 for rate codes 0, 1, 2 and 3. Bit 7-k of the written byte is on `mosi` during half-periods 2k and 2k+1. The completion flag is set 16·H clocks after the write edge.
- R7: When idle, `sck` equals the polarity bit. During a transfer `sck` is at the opposite level in the odd half-periods when the phase bit is 0, and in the even half-periods when the phase bit is 1.
- R8: `miso` is sampled at the end of each even half-period, first bit in being the MSB. At the end of the transfer the received byte becomes the value read at address 2.
- R9: `irq` is high exactly while the completion flag and the interrupt enable bit are both 1.
- R10: A status read records the flags that are set at that moment. The next read of address 2, or accepted write to it, clears only the recorded flags. A flag that becomes set after the status read survives that access.
- R11: A reset during a transfer ends the transfer, returns `sck` to low, discards any recorded flags and clears the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Single-cycle write strobe |
| regRd | input | 1 | Single-cycle read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
A wrong half-period count or rate decode moves the `sck` edges and the `mosi` bit changes within one half-period of the start, and it moves the rise of `irq` at the end. Each of these appears on the first affected clock. A wrong capture edge or shift order shows only at the next read of the data register, one transfer later. A stale or over-eager clear latch shows as a status value that is wrong on the read that follows the data access. The reference model is therefore compared on `sck`, `mosi` and `irq` every clock, and on every register read.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int CTRL_IE   = 7;
  localparam int CTRL_EN   = 6;
  localparam int CTRL_CPOL = 3;
  localparam int CTRL_CPHA = 2;
  localparam int TMR_W     = 5;

  // Strobes from the control side to the shift datapath
  typedef struct packed {
    logic load;    // capture the write byte, start of transfer
    logic sample;  // capture miso into the hold bit
    logic shift;   // advance the shift register by one bit
    logic finish;  // last half-period ends, publish the received byte
  } xferStrobe_t;

  // Half-period length in system clocks for each rate code
  function automatic logic [TMR_W-1:0] halfLen(input logic [1:0] code);
    logic [TMR_W-1:0] base;
    base = code[1] ? TMR_W'(8) : TMR_W'(1);
    return code[0] ? (base << 1) : base;
  endfunction

endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              doneFlag,
  output logic              colFlag,
  output logic              busy,
  output logic              sckOut,
  output xferStrobe_t       strobe
);

  localparam int HALVES = 2 * DATA_W;
  localparam int HIDX_W = $clog2(HALVES);

  logic [TMR_W-1:0]  tmr;
  logic [HIDX_W-1:0] halfIdx;
  logic              latchDone, latchCol;
  logic              enable, dataSel, accept, startXfer, collide;
  logic              dataAccess, statusRead, tick, lastHalf;

  assign enable     = ctrlReg[CTRL_EN];
  assign dataSel    = (addr == 2'd2);
  assign accept     = wrEn && dataSel && enable;
  assign startXfer  = accept && !busy;
  assign collide    = accept && busy;
  assign dataAccess = dataSel && (rdEn || accept);
  assign statusRead = rdEn && (addr == 2'd1);
  assign tick       = busy && (tmr == halfLen(ctrlReg[1:0]) - TMR_W'(1));
  assign lastHalf   = (halfIdx == HIDX_W'(HALVES - 1));

  always_comb begin
    strobe.load   = startXfer;
    strobe.sample = tick && !halfIdx[0];
    strobe.shift  = tick && halfIdx[0] && !lastHalf;
    strobe.finish = tick && lastHalf;
  end

  // Active level in odd halves for phase 0, even halves for phase 1
  assign sckOut = ctrlReg[CTRL_CPOL] ^ (busy & (halfIdx[0] ^ ctrlReg[CTRL_CPHA]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg   <= '0;
      busy      <= 1'b0;
      tmr       <= '0;
      halfIdx   <= '0;
      doneFlag  <= 1'b0;
      colFlag   <= 1'b0;
      latchDone <= 1'b0;
      latchCol  <= 1'b0;
    end else begin
      if (wrEn && addr == 2'd0) ctrlReg <= wrData;

      if (startXfer) begin
        busy    <= 1'b1;
        tmr     <= '0;
        halfIdx <= '0;
      end else if (busy) begin
        if (tick) begin
          tmr <= '0;
          if (lastHalf) busy <= 1'b0;
          else          halfIdx <= halfIdx + HIDX_W'(1);
        end else begin
          tmr <= tmr + TMR_W'(1);
        end
      end

      doneFlag <= (doneFlag & ~(dataAccess & latchDone)) | strobe.finish;
      colFlag  <= (colFlag  & ~(dataAccess & latchCol))  | collide;

      if (statusRead) begin
        latchDone <= doneFlag;
        latchCol  <= colFlag;
      end else if (dataAccess) begin
        latchDone <= 1'b0;
        latchCol  <= 1'b0;
      end
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd0) |=> ctrlReg == $past(wrData)); // R2
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd2 && !ctrlReg[CTRL_EN] && !busy) |=> !busy); // R4
  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == 2'd2 && ctrlReg[CTRL_EN] && busy) |=> colFlag); // R5
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $fell(busy)); // R6

endmodule

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xferStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxBuf
);

  logic [DATA_W-1:0] shiftReg;
  logic              capBit;

  assign mosi = shiftReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      capBit   <= 1'b0;
      rxBuf    <= '0;
    end else begin
      if (strobe.load)   shiftReg <= wrData;
      if (strobe.sample) capBit   <= miso;
      if (strobe.shift)  shiftReg <= {shiftReg[DATA_W-2:0], capBit};
      if (strobe.finish) rxBuf    <= {shiftReg[DATA_W-2:0], capBit};
    end
  end

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> mosi == $past(wrData[DATA_W-1])); // R6
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.sample, strobe.shift, strobe.finish})); // R8

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  xferStrobe_t       strobe;
  logic [DATA_W-1:0] ctrlReg, rxBuf;
  logic              doneFlag, colFlag, busy;

  spi_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .addr(regAddr), .wrEn(regWr), .rdEn(regRd),
    .wrData(regWrData), .ctrlReg(ctrlReg), .doneFlag(doneFlag),
    .colFlag(colFlag), .busy(busy), .sckOut(sck), .strobe(strobe)
  );

  spi_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(regWrData),
    .miso(miso), .mosi(mosi), .rxBuf(rxBuf)
  );

  assign irq = doneFlag & ctrlReg[CTRL_IE];

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = ctrlReg;
      2'd1:    regRdData = {doneFlag, colFlag, {(DATA_W-2){1'b0}}};
      2'd2:    regRdData = rxBuf;
      default: regRdData = '0;
    endcase
  end

endmodule

// File: tb/tb_spi_reg_master.sv
module tb_spi_reg_master;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  always #2 clk = ~clk;

  spi_reg_master dut (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  bit mValid = 0;

  // Reference model state (state after the most recent rising edge)
  logic [7:0] mCtrl = 0, mTx = 0, mRx = 0, mSlave = 0;
  bit mBusy = 0, mDone = 0, mCol = 0, mLatD = 0, mLatC = 0;
  int mEl = 0;

  function automatic int hl(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mCtrl;
      2'd1: return {mDone, mCol, 6'b0};
      2'd2: return mRx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [7:0] d, input logic rs, input string tag);
    int h, hh;
    bit act, dataAcc, en, setCol, fin, clrD, clrC;
    @(negedge clk);
    hh = hl(mCtrl[1:0]);
    h  = mEl / hh;
    if (mValid) begin
      act = mCtrl[2] ? (h % 2 == 0) : (h % 2 == 1);
      chk({7'b0, sck}, {7'b0, mCtrl[3] ^ (mBusy && act)}, "R7", "sck");
      if (mBusy) chk({7'b0, mosi}, {7'b0, mTx[7 - h/2]}, "R6", "mosi");
      chk({7'b0, irq}, {7'b0, mDone && mCtrl[7]}, "R9", "irq");
    end
    rst = rs; regWr = w; regRd = r; regAddr = a; regWrData = d;
    miso = mBusy ? mSlave[7 - h/2] : 1'b0;
    #1;
    if (r && !rs && mValid) chk(regRdData, expRead(a), tag, "read");
    if (rs) begin
      mCtrl = 0; mBusy = 0; mEl = 0; mDone = 0; mCol = 0;
      mLatD = 0; mLatC = 0; mRx = 0; mTx = 0; mValid = 1;
    end else begin
      en      = mCtrl[6];
      dataAcc = (a == 2'd2) && (r || (w && en));
      setCol  = w && (a == 2'd2) && en && mBusy;
      fin     = mBusy && (mEl == 16*hh - 1);
      clrD    = dataAcc && mLatD;
      clrC    = dataAcc && mLatC;
      if (r && a == 2'd1) begin mLatD = mDone; mLatC = mCol; end
      else if (dataAcc) begin mLatD = 0; mLatC = 0; end
      mDone = (mDone && !clrD) || fin;
      mCol  = (mCol && !clrC) || setCol;
      if (fin) begin mBusy = 0; mRx = mSlave; end
      else if (mBusy) mEl++;
      else if (w && a == 2'd2 && en) begin mBusy = 1; mEl = 0; mTx = d; end
      if (w && a == 2'd0) mCtrl = d;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00, 0, "R6");
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(1, 0, a, d, 0, tag);
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    cyc(0, 1, a, 8'h00, 0, tag);
  endtask
  task automatic waitDone();
    for (int i = 0; i < 2000 && mBusy; i++) idle(1);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL R6 watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    cyc(0, 0, 2'd0, 8'h00, 1, "R1");
    cyc(0, 0, 2'd0, 8'h00, 1, "R1");
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");

    // R2: control readback
    wr(2'd0, 8'hB5, "R2"); rd(2'd0, "R2");
    wr(2'd0, 8'h3A, "R2"); rd(2'd0, "R2");

    // R4: data write with enable clear
    wr(2'd0, 8'h88, "R4");
    wr(2'd2, 8'h5A, "R4"); idle(6);
    rd(2'd1, "R4"); rd(2'd2, "R4");

    // R6 R7 R8: every polarity, phase and rate
    for (int i = 0; i < 16; i++) begin
      mSlave = 8'h3C + 8'(i * 19);
      wr(2'd0, 8'hC0 | 8'(i), "R2");
      wr(2'd2, 8'h96 ^ 8'(i * 37), "R6");
      waitDone();
      if (i == 0) begin
        wr(2'd1, 8'h00, "R3"); rd(2'd1, "R3");
      end
      rd(2'd1, "R10"); rd(2'd2, "R8"); rd(2'd1, "R10");
    end

    // R5: collision keeps transfer intact
    mSlave = 8'hE1;
    wr(2'd0, 8'hC1, "R5");
    wr(2'd2, 8'hA5, "R5"); idle(3);
    wr(2'd2, 8'h11, "R5"); rd(2'd1, "R5");
    waitDone();
    rd(2'd1, "R5"); rd(2'd2, "R8"); rd(2'd1, "R10");

    // R10: flag set after status read survives
    mSlave = 8'h4D;
    wr(2'd0, 8'hC0, "R10");
    wr(2'd2, 8'h7E, "R10"); rd(2'd1, "R10");
    waitDone();
    rd(2'd2, "R10"); rd(2'd1, "R10");
    rd(2'd2, "R10"); rd(2'd1, "R10");

    // R10: an accepted data write clears the recorded flag
    wr(2'd2, 8'h0F, "R10"); waitDone();
    rd(2'd1, "R10");
    wr(2'd2, 8'hF0, "R10"); rd(2'd1, "R10"); waitDone(); rd(2'd1, "R10");
    rd(2'd2, "R8");

    // R9: no interrupt without enable
    wr(2'd0, 8'h40, "R9");
    rd(2'd1, "R9"); rd(2'd2, "R9");
    wr(2'd2, 8'h33, "R9"); waitDone(); rd(2'd1, "R9");

    // R11: reset mid-transfer
    wr(2'd0, 8'hCF, "R11");
    rd(2'd1, "R11");
    wr(2'd2, 8'hC3, "R11"); idle(40);
    cyc(0, 0, 2'd0, 8'h00, 1, "R11");
    rd(2'd0, "R11"); rd(2'd1, "R11"); rd(2'd2, "R11"); idle(5);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule